// File: doc/BRIEF.md
# Timer Interrupt Vector Controller

This block gathers the interrupt flags of a multi-channel timer and drives two request lines and a vector word. Channel 0 has a request line of its own, which outranks the other. The other capture/compare channels (1 to NUM_CH-1) and the counter overflow share a second line. The block holds the flags itself. The timer logic raises them with one-cycle set strobes. They are cleared in one of two ways: an acknowledge strobe for channel 0, or a read strobe on the vector word for the shared sources.

`vector_o` shows a code for the highest-priority shared source whose flag and enable are both set. If nothing is pending, it shows 0. Asserting `vec_rd_i` for one cycle models a processor read of the vector: at that clock edge, the flag of the source being reported is cleared. Repeated reads therefore walk through the pending sources in priority order. Disabled flags stay latched but raise no request and are never reported.

Top module: `ivr_vector_ctrl`

## Requirements
- R1: A set strobe on any source makes its flag visible in `flags_o` on the next cycle. `irq0_o` is high exactly while the channel-0 flag and `ch0_en_i` are both set.
- R2: `ack0_i` clears the channel-0 flag at the next edge and leaves every other flag unchanged.
- R3: `irq1_o` is high exactly while at least one shared source has both its flag and its enable set. A disabled flag raises no request and is not reported in the vector.
- R4: Pending channel n (1 <= n <= NUM_CH-1) reads as code 2*n. Overflow reads as 0x0A when NUM_CH <= 5, and as 2*NUM_CH otherwise. Bit 0 of the vector is always 0.
- R5: Among pending shared sources, the lowest-numbered channel is reported first. Overflow is reported last.
- R6: A read strobe clears exactly the flag being reported at that edge. When no other enabled shared flag remains pending, `irq1_o` drops.
- R7: With no enabled shared source pending, the vector reads 0 and a read strobe changes no flag.
- R8: If a set strobe and a clear (read or acknowledge) hit the same flag in the same cycle, the flag stays set.
- R9: Channel 0 never appears in the vector, and a read strobe never clears the channel-0 flag.
- R10: After reset, all flags are clear, both requests are low and the vector reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch0_set_i | input | 1 | Set strobe for the channel-0 flag |
| ch0_en_i | input | 1 | Channel-0 interrupt enable |
| ch_set_i | input | NUM_CH-1 | Set strobes for channels 1..NUM_CH-1 (bit k is channel k+1) |
| ch_en_i | input | NUM_CH-1 | Enables for channels 1..NUM_CH-1 (bit k is channel k+1) |
| ovf_set_i | input | 1 | Set strobe for the overflow flag |
| ovf_en_i | input | 1 | Overflow interrupt enable |
| ack0_i | input | 1 | Acknowledge of the channel-0 request; clears its flag |
| vec_rd_i | input | 1 | Vector read strobe; clears the reported source |
| irq0_o | output | 1 | Channel-0 request |
| irq1_o | output | 1 | Shared request for channels 1.. and overflow |
| vector_o | output | VEC_W | Code of the highest-priority pending shared source, 0 if none |
| flags_o | output | NUM_CH+1 | Flag state: bit 0 is channel 0, bit n is channel n, bit NUM_CH is overflow |

## Verification
The bench builds the block with NUM_CH = 5 and VEC_W = 16. Five channels is the largest count at which overflow keeps code 0x0A. This puts channel 4 (code 0x08) right next to overflow in priority, and a full read sequence of channels 1 to 4 followed by overflow can be run. With this width, codes up to 0x0A appear on the vector and its unused upper bits are checked to stay 0.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  // code for shared source idx: idx < num_ch-1 -> channel idx+1, else overflow
  function automatic int unsigned shared_code(int unsigned idx, int unsigned num_ch);
    if (idx < num_ch - 1) return 2 * (idx + 1);
    return (num_ch <= 5) ? 10 : 2 * num_ch;
  endfunction
endpackage

// File: rtl/ivr_flag_bank.sv
module ivr_flag_bank #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[g] <= 1'b0;
      else if (set_i[g]) flag_o[g] <= 1'b1;  // new event wins over clear
      else if (clr_i[g]) flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ivr_prio_enc.sv
module ivr_prio_enc #(
  parameter int unsigned WIDTH = 4
) (
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivr_code_map.sv
module ivr_code_map
  import ivr_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned VEC_W  = 16
) (
  input  logic [NUM_CH-1:0] gnt_i,
  output logic [VEC_W-1:0]  code_o
);
  logic [VEC_W-1:0] part [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_code
    localparam logic [VEC_W-1:0] CODE = VEC_W'(shared_code(g, NUM_CH));
    assign part[g] = gnt_i[g] ? CODE : '0;
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_CH; i++) code_o |= part[i];
  end
endmodule

// File: rtl/ivr_vector_ctrl.sv
module ivr_vector_ctrl #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned VEC_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ch0_set_i,
  input  logic              ch0_en_i,
  input  logic [NUM_CH-2:0] ch_set_i,
  input  logic [NUM_CH-2:0] ch_en_i,
  input  logic              ovf_set_i,
  input  logic              ovf_en_i,
  input  logic              ack0_i,
  input  logic              vec_rd_i,
  output logic              irq0_o,
  output logic              irq1_o,
  output logic [VEC_W-1:0]  vector_o,
  output logic [NUM_CH:0]   flags_o
);
  localparam int unsigned NSRC  = NUM_CH;      // shared sources incl. overflow
  localparam int unsigned NFLAG = NUM_CH + 1;

  logic [NFLAG-1:0] set_vec, clr_vec, flags;
  logic [NSRC-1:0]  shared_req, gnt;

  assign set_vec = {ovf_set_i, ch_set_i, ch0_set_i};

  // only the reported source is cleared by a read
  assign clr_vec = {gnt & {NSRC{vec_rd_i}}, ack0_i};

  ivr_flag_bank #(.WIDTH(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .flag_o (flags)
  );

  assign shared_req = flags[NFLAG-1:1] & {ovf_en_i, ch_en_i};

  ivr_prio_enc #(.WIDTH(NSRC)) u_enc (
    .req_i (shared_req),
    .gnt_o (gnt)
  );

  ivr_code_map #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_map (
    .gnt_i  (gnt),
    .code_o (vector_o)
  );

  assign irq0_o  = flags[0] & ch0_en_i;
  assign irq1_o  = |shared_req;
  assign flags_o = flags;
endmodule

// File: rtl/ivr_vector_ctrl_chk.sv
module ivr_vector_ctrl_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned VEC_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ch0_set_i,
  input logic [NUM_CH-2:0] ch_set_i,
  input logic              ovf_set_i,
  input logic              ack0_i,
  input logic              vec_rd_i,
  input logic              irq1_o,
  input logic [VEC_W-1:0]  vector_o,
  input logic [NUM_CH:0]   flags_o
);
  a_r1_ch0_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch0_set_i |=> flags_o[0]);

  a_r2_ack_only_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack0_i && !vec_rd_i) |=>
      ((flags_o[NUM_CH:1] & $past(flags_o[NUM_CH:1])) == $past(flags_o[NUM_CH:1])));

  a_r3_idle_vector_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq1_o |-> (vector_o == '0));

  a_r4_even_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vector_o[0]);

  a_r6_one_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_rd_i |=> ($countones($past(flags_o[NUM_CH:1]) & ~flags_o[NUM_CH:1]) <= 1));

  a_r7_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && !ack0_i && vector_o == '0) |=>
      ((flags_o & $past(flags_o)) == $past(flags_o)));

  a_r8_ovf_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_i |=> flags_o[NUM_CH]);

  a_r8_ch1_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_set_i[0] |=> flags_o[1]);

  a_r9_read_keeps_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_rd_i && !ack0_i) |=> !$fell(flags_o[0]));
endmodule

bind ivr_vector_ctrl ivr_vector_ctrl_chk #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/ivr_vector_ctrl_tb.sv
module ivr_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 5;
  localparam int VEC_W  = 16;
  localparam int NS     = NUM_CH - 1;
  localparam logic [VEC_W-1:0] OVF_CODE = 16'h000A;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ch0_set_i = 0, ch0_en_i = 0, ovf_set_i = 0, ovf_en_i = 0, ack0_i = 0, vec_rd_i = 0;
  logic [NS-1:0] ch_set_i = '0, ch_en_i = '0;
  logic irq0_o, irq1_o;
  logic [VEC_W-1:0] vector_o;
  logic [NUM_CH:0] flags_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ivr_vector_ctrl #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_dut (.*);

  typedef struct packed {
    logic [NUM_CH:0]  flags;
    logic             irq0;
    logic             irq1;
    logic [VEC_W-1:0] vec;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, fails = 0;
  bit done = 0, summary_done = 0;

  // bench-side state and intended enables
  logic [NUM_CH:0] m_flags = '0;
  logic w_en0 = 0, w_ovf_en = 0;
  logic [NS-1:0] w_ch_en = '0;

  function automatic int first_pending(logic [NUM_CH:0] f, logic [NS-1:0] e, logic oe);
    for (int i = 1; i < NUM_CH; i++) if (f[i] && e[i-1]) return i;
    if (f[NUM_CH] && oe) return NUM_CH;
    return 0;
  endfunction

  function automatic logic [VEC_W-1:0] code_of(int src);
    if (src == 0) return '0;
    if (src == NUM_CH) return OVF_CODE;
    return VEC_W'(2 * src);
  endfunction

  task automatic step(input string tag, input logic s0, input logic [NS-1:0] s,
                      input logic so, input logic ack, input logic rd);
    exp_t e;
    int   src;
    logic [NUM_CH:0] f;
    @(negedge clk_i);
    ch0_en_i = w_en0; ch_en_i = w_ch_en; ovf_en_i = w_ovf_en;
    ch0_set_i = s0; ch_set_i = s; ovf_set_i = so; ack0_i = ack; vec_rd_i = rd;
    f   = m_flags;
    src = first_pending(f, w_ch_en, w_ovf_en);
    if (rd && src != 0) f[src] = 1'b0;
    if (ack) f[0] = 1'b0;
    f = f | {so, s, s0};
    m_flags = f;
    e.flags = f;
    e.irq0  = f[0] & w_en0;
    src     = first_pending(f, w_ch_en, w_ovf_en);
    e.irq1  = (src != 0);
    e.vec   = code_of(src);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  // monitor: compare each cycle's outputs against the queued expectation
  initial forever begin
    @(posedge clk_i);
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (flags_o !== e.flags || irq0_o !== e.irq0 || irq1_o !== e.irq1 || vector_o !== e.vec) begin
        fails++;
        $display("FAIL %s: flags=%b irq0=%b irq1=%b vec=%h expected flags=%b irq0=%b irq1=%b vec=%h",
                 t, flags_o, irq0_o, irq1_o, vector_o, e.flags, e.irq0, e.irq1, e.vec);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (flags_o !== '0 || irq0_o !== 0 || irq1_o !== 0 || vector_o !== '0) begin
      fails++;
      $display("FAIL R10 reset: flags=%b irq0=%b irq1=%b vec=%h expected all zero",
               flags_o, irq0_o, irq1_o, vector_o);
    end
    rst_ni = 1'b1;

    // R1: channel-0 flag and request
    w_en0 = 1;
    step("R1 ch0 set", 1'b1, '0, 1'b0, 1'b0, 1'b0);
    // R2: ack clears ch0 only (ch2 pending, enabled)
    w_ch_en = 4'b1111; w_ovf_en = 1;
    step("R2 set ch2", 1'b0, 4'b0010, 1'b0, 1'b0, 1'b0);
    step("R2 ack0", 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R4/R6: read ch2 -> code 4, then shared line drops
    step("R6 read ch2", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R5: several pending, lowest first, overflow last
    step("R5 set ch1 ch3 ch4 ovf", 1'b0, 4'b1101, 1'b1, 1'b0, 1'b0);
    step("R5 read ch1", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    step("R5 read ch3", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    step("R4 read ch4 code 8", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    step("R4 read ovf code 0A", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R7: empty read has no effect
    step("R7 empty read", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R3: disabled channel 2 latches but raises nothing
    w_ch_en = 4'b1101;
    step("R3 set disabled ch2", 1'b0, 4'b0010, 1'b0, 1'b0, 1'b0);
    step("R7 read with only disabled", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    w_ch_en = 4'b1111;
    idle("R3 enable ch2 reports 4");
    step("R6 read ch2 after enable", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R8: set and read of same source in same cycle
    step("R8 set ch1", 1'b0, 4'b0001, 1'b0, 1'b0, 1'b0);
    step("R8 read+set ch1", 1'b0, 4'b0001, 1'b0, 1'b0, 1'b1);
    step("R8 ack+set ch0", 1'b1, '0, 1'b0, 1'b1, 1'b0);
    // R9: read never touches ch0, ch0 never in vector
    step("R9 read ch1 with ch0 pending", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    step("R9 read empty with ch0 pending", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    // R1: ch0 enable gates its request
    w_en0 = 0;
    idle("R1 ch0 disabled");
    w_en0 = 1;
    step("R2 ack ch0", 1'b0, '0, 1'b0, 1'b1, 1'b0);
    // R3: disabled overflow ignored, lower channel still reported
    w_ovf_en = 0;
    step("R3 ovf disabled, ch3 set", 1'b0, 4'b0100, 1'b1, 1'b0, 1'b0);
    step("R5 read ch3", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    w_ovf_en = 1;
    idle("R4 ovf enabled");
    step("R6 read ovf", 1'b0, '0, 1'b0, 1'b0, 1'b1);
    idle("R6 idle");
    @(negedge clk_i);
    @(negedge clk_i);
    done = 1;
    if (!summary_done) begin
      summary_done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done && !summary_done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      summary_done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule